// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the architectural registers of a 32-bit processor core that runs in several operating modes. An architectural register number from 0 to 15 is turned into a physical storage slot according to the mode currently held in the status register. This lets the fast-interrupt mode and the other privileged modes keep private stack-pointer and link registers, and the fast-interrupt mode also keeps private working registers, without disturbing the registers of the interrupted code. Register 15 is the program counter and is held outside the banked array.

The core reads two operands per cycle through combinational ports and retires one result per clock through the write port. The status register can be written as a whole. When the exception logic enters a privileged mode, it raises an entry strobe together with the target mode and the return address. In one clock edge the block then saves the current status into that mode's saved-status register, loads the return address into that mode's link register and switches the mode. A return strobe restores the status from the saved copy of the current mode. Two flags report an unknown mode encoding and, in the narrow instruction state, any attempt to address r8 to r12.

Top module: `bankreg_file`

## Requirements
- R1: A synchronous active-high reset clears every register and the program counter, clears all saved-status registers, and sets the status register to 0x00000013. The status bits [4:0] hold the mode, and 10011 is supervisor mode.
- R2: The mode encodings are: 10000 user, 10001 fast interrupt, 10010 interrupt, 10011 supervisor, 10111 abort, 11011 undefined, 11111 system. User and system modes address one common set r0–r14, and r0–r7 are the same storage in every mode.
- R3: In fast-interrupt mode, r8–r14 are private copies. Writes to them leave the user copies unchanged, and their contents survive a switch to user mode and back.
- R4: Supervisor, abort, undefined and interrupt modes each have private r13 and r14. In these modes r0–r12 are the user registers.
- R5: A general write to r15 loads the program counter. A read of r15 on either port returns the stored program counter plus 8.
- R6: An exception-entry strobe with a privileged target mode does all of the following in one edge. It copies the status register into the target mode's saved-status register and writes the return address into the target mode's r14. It sets status[4:0] to the target mode, clears status bit 5 (the narrow-state bit) and keeps status[31:6].
- R7: In the cycle of a valid exception-entry strobe, both a general register write and a status write are discarded.
- R8: An exception-entry strobe whose target is user, system or an unknown encoding changes nothing.
- R9: A return strobe in a privileged mode copies that mode's saved-status register into the status register. In user, system or an unknown mode the strobe is ignored.
- R10: The saved-status output shows the saved-status register of the current mode. It is zero in user, system or an unknown mode.
- R11: When status bit 5 is set, the illegal-access flag is high whenever a read address, or the write address with the write enable high, lies in r8–r12. Otherwise the flag is low.
- R12: A status mode field outside the seven encodings raises the mode-error flag, and register banking then uses the user set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_addr | input | 4 | Read port A architectural register number |
| rd_a_data | output | DATA_W | Read port A data (combinational) |
| rd_b_addr | input | 4 | Read port B architectural register number |
| rd_b_data | output | DATA_W | Read port B data (combinational) |
| wr_en | input | 1 | General write enable |
| wr_addr | input | 4 | General write register number |
| wr_data | input | DATA_W | General write data |
| st_we | input | 1 | Status register write enable |
| st_wdata | input | DATA_W | New status register value |
| exc_en | input | 1 | Exception-entry strobe |
| exc_mode | input | 5 | Target mode of the exception |
| exc_ret_addr | input | DATA_W | Return address for the target link register |
| ret_en | input | 1 | Return-from-exception strobe |
| status_o | output | DATA_W | Current status register |
| saved_status_o | output | DATA_W | Saved-status register of the current mode |
| mode_err | output | 1 | Current mode encoding is unknown |
| narrow_err | output | 1 | Narrow state and r8–r12 addressed |

## Verification
The banking is exercised by writing one distinct pattern per register in user mode and then reading through each mode. Reads that come back unchanged separate shared slots from private ones, and reads that return zero show a private bank that has not yet been written. Exception entry is driven with a competing register write and a competing status write in the same cycle, so that priority errors and a missing save, link load or mode switch each show up as a different wrong value. Return strobes are applied in a privileged mode and in user mode, to tell a restore apart from an ignored strobe. Narrow-state checks step the addresses across the r7/r8 and r12/r13 edges on both read ports and on the write port.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;
  localparam int ARCH_W     = 4;
  localparam int MODE_W     = 5;
  localparam int NPHYS      = 30;
  localparam int PIDX_W     = $clog2(NPHYS);
  localparam int NSAVED     = 5;
  localparam int SLOT_W     = $clog2(NSAVED);
  localparam int NARROW_BIT = 5;

  // physical layout: user r0..r14 at 0..14, then private banks
  localparam int FINT_BASE = 15;
  localparam int SUP_BASE  = 22;
  localparam int ABT_BASE  = 24;
  localparam int UND_BASE  = 26;
  localparam int INT_BASE  = 28;

  typedef enum logic [MODE_W-1:0] {
    M_USER = 5'b10000,
    M_FINT = 5'b10001,
    M_INT  = 5'b10010,
    M_SUP  = 5'b10011,
    M_ABT  = 5'b10111,
    M_UND  = 5'b11011,
    M_SYS  = 5'b11111
  } mode_e;

  function automatic logic mode_known(logic [MODE_W-1:0] m);
    case (m)
      M_USER, M_FINT, M_INT, M_SUP, M_ABT, M_UND, M_SYS: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic mode_priv(logic [MODE_W-1:0] m);
    case (m)
      M_FINT, M_INT, M_SUP, M_ABT, M_UND: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [SLOT_W-1:0] saved_slot(logic [MODE_W-1:0] m);
    case (m)
      M_FINT:  return SLOT_W'(0);
      M_INT:   return SLOT_W'(1);
      M_SUP:   return SLOT_W'(2);
      M_ABT:   return SLOT_W'(3);
      M_UND:   return SLOT_W'(4);
      default: return SLOT_W'(0);
    endcase
  endfunction

  function automatic logic [PIDX_W-1:0] phys_of(logic [ARCH_W-1:0] a, logic [MODE_W-1:0] m);
    logic [PIDX_W-1:0] p;
    logic              top2;
    p    = PIDX_W'(a);
    top2 = (a == 4'd13) || (a == 4'd14);
    case (m)
      M_FINT: if (a >= 4'd8 && a <= 4'd14) p = PIDX_W'(FINT_BASE) + PIDX_W'(a - 4'd8);
      M_SUP:  if (top2) p = PIDX_W'(SUP_BASE) + PIDX_W'(a - 4'd13);
      M_ABT:  if (top2) p = PIDX_W'(ABT_BASE) + PIDX_W'(a - 4'd13);
      M_UND:  if (top2) p = PIDX_W'(UND_BASE) + PIDX_W'(a - 4'd13);
      M_INT:  if (top2) p = PIDX_W'(INT_BASE) + PIDX_W'(a - 4'd13);
      default: ;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/bankreg_map.sv
module bankreg_map
  import bankreg_pkg::*;
(
  input  logic [ARCH_W-1:0] arch_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic [PIDX_W-1:0] phys_o,
  output logic              is_pc_o,
  output logic              is_hi_o
);
  assign phys_o  = phys_of(arch_i, mode_i);
  assign is_pc_o = (arch_i == 4'd15);
  assign is_hi_o = (arch_i >= 4'd8) && (arch_i <= 4'd12);
endmodule

// File: rtl/bankreg_store.sv
module bankreg_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 30,
  parameter int NRD    = 2,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i [NRD],
  output logic [DATA_W-1:0] rdata_o [NRD]
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we_i) begin
      mem[waddr_i] <= wdata_i;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata_o[g] = mem[raddr_i[g]];
  end
endmodule

// File: rtl/bankreg_status.sv
module bankreg_status
  import bankreg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              st_we_i,
  input  logic [DATA_W-1:0] st_wdata_i,
  input  logic              exc_en_i,
  input  logic [MODE_W-1:0] exc_mode_i,
  input  logic              ret_en_i,
  output logic [DATA_W-1:0] status_o,
  output logic [DATA_W-1:0] saved_cur_o,
  output logic              exc_take_o
);
  localparam logic [DATA_W-1:0] RESET_STATUS = {{(DATA_W-MODE_W){1'b0}}, M_SUP};

  logic [DATA_W-1:0] status_q;
  logic [DATA_W-1:0] saved_q [NSAVED];
  logic              cur_priv;
  logic              exc_ok;

  assign exc_ok   = exc_en_i && mode_priv(exc_mode_i);
  assign cur_priv = mode_priv(status_q[MODE_W-1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= RESET_STATUS;
      for (int i = 0; i < NSAVED; i++) saved_q[i] <= '0;
    end else if (exc_ok) begin
      saved_q[saved_slot(exc_mode_i)] <= status_q;
      status_q <= {status_q[DATA_W-1:NARROW_BIT+1], 1'b0, exc_mode_i};
    end else if (ret_en_i && cur_priv) begin
      status_q <= saved_q[saved_slot(status_q[MODE_W-1:0])];
    end else if (st_we_i) begin
      status_q <= st_wdata_i;
    end
  end

  assign status_o    = status_q;
  assign saved_cur_o = cur_priv ? saved_q[saved_slot(status_q[MODE_W-1:0])] : '0;
  assign exc_take_o  = exc_ok;

  AST_EXC_SAVE: assert property (@(posedge clk) disable iff (rst)
    exc_ok |=> saved_cur_o == $past(status_q)); // R6
  AST_EXC_MODE_WINS: assert property (@(posedge clk) disable iff (rst)
    exc_ok |=> status_q[MODE_W-1:0] == $past(exc_mode_i)); // R7
  AST_BAD_EXC_NOP: assert property (@(posedge clk) disable iff (rst)
    (exc_en_i && !exc_ok && !ret_en_i && !st_we_i) |=> $stable(status_q)); // R8
  AST_RET_RESTORE: assert property (@(posedge clk) disable iff (rst)
    (!exc_ok && ret_en_i && cur_priv) |=> status_q == $past(saved_cur_o)); // R9
  AST_RET_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!exc_en_i && ret_en_i && !cur_priv && !st_we_i) |=> $stable(status_q)); // R9
endmodule

// File: rtl/bankreg_file.sv
module bankreg_file
  import bankreg_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int PC_AHEAD = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        rd_a_addr,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [3:0]        rd_b_addr,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              st_we,
  input  logic [DATA_W-1:0] st_wdata,
  input  logic              exc_en,
  input  logic [4:0]        exc_mode,
  input  logic [DATA_W-1:0] exc_ret_addr,
  input  logic              ret_en,
  output logic [DATA_W-1:0] status_o,
  output logic [DATA_W-1:0] saved_status_o,
  output logic              mode_err,
  output logic              narrow_err
);
  localparam int NRD   = 2;
  localparam int NPORT = NRD + 1;   // read ports then the write port
  localparam int WP    = NRD;

  logic [DATA_W-1:0] status_w;
  logic              exc_take;
  logic [MODE_W-1:0] cur_mode, eff_mode;
  logic [DATA_W-1:0] pc_q;

  logic [ARCH_W-1:0] arch_sel [NPORT];
  logic [PIDX_W-1:0] phys_sel [NPORT];
  logic              pc_sel   [NPORT];
  logic              hi_sel   [NPORT];
  logic [PIDX_W-1:0] rd_phys  [NRD];
  logic [DATA_W-1:0] rd_store [NRD];
  logic [DATA_W-1:0] rd_val   [NRD];

  logic              st_wr;
  logic [PIDX_W-1:0] st_waddr;
  logic [DATA_W-1:0] st_wval;

  bankreg_status #(.DATA_W(DATA_W)) u_status (
    .clk(clk), .rst(rst),
    .st_we_i(st_we), .st_wdata_i(st_wdata),
    .exc_en_i(exc_en), .exc_mode_i(exc_mode), .ret_en_i(ret_en),
    .status_o(status_w), .saved_cur_o(saved_status_o), .exc_take_o(exc_take)
  );

  assign cur_mode = status_w[MODE_W-1:0];
  assign eff_mode = mode_known(cur_mode) ? cur_mode : M_USER;

  assign arch_sel[0]  = rd_a_addr;
  assign arch_sel[1]  = rd_b_addr;
  assign arch_sel[WP] = wr_addr;

  for (genvar g = 0; g < NPORT; g++) begin : g_map
    bankreg_map u_map (
      .arch_i(arch_sel[g]), .mode_i(eff_mode),
      .phys_o(phys_sel[g]), .is_pc_o(pc_sel[g]), .is_hi_o(hi_sel[g])
    );
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_phys[g] = phys_sel[g];
    assign rd_val[g]  = pc_sel[g] ? pc_q + DATA_W'(PC_AHEAD) : rd_store[g];
  end

  // one physical write port: exception link load wins over the general write
  assign st_wr    = exc_take || (wr_en && !pc_sel[WP]);
  assign st_waddr = exc_take ? phys_of(4'd14, exc_mode) : phys_sel[WP];
  assign st_wval  = exc_take ? exc_ret_addr : wr_data;

  bankreg_store #(.DATA_W(DATA_W), .DEPTH(NPHYS), .NRD(NRD)) u_store (
    .clk(clk), .rst(rst),
    .we_i(st_wr), .waddr_i(st_waddr), .wdata_i(st_wval),
    .raddr_i(rd_phys), .rdata_o(rd_store)
  );

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else if (!exc_take && wr_en && pc_sel[WP]) pc_q <= wr_data;
  end

  assign rd_a_data  = rd_val[0];
  assign rd_b_data  = rd_val[1];
  assign status_o   = status_w;
  assign mode_err   = !mode_known(cur_mode);
  assign narrow_err = status_w[NARROW_BIT] &&
                      (hi_sel[0] || hi_sel[1] || (wr_en && hi_sel[WP]));

  AST_PC_AHEAD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 4'd15 && !exc_take) |=>
      (rd_a_addr != 4'd15 || rd_a_data == $past(wr_data) + DATA_W'(PC_AHEAD))); // R5
  AST_EXC_LINK: assert property (@(posedge clk) disable iff (rst)
    exc_take |=> (rd_a_addr != 4'd14 || rd_a_data == $past(exc_ret_addr))); // R6
  AST_NARROW_LOW: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && rd_a_addr < 4'd8 && rd_b_addr < 4'd8) |-> !narrow_err); // R11
  AST_WIDE_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
    !status_o[NARROW_BIT] |-> !narrow_err); // R11
endmodule

// File: tb/test_bankreg_file.sv
module test_bankreg_file;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [3:0]    rd_a_addr = '0, rd_b_addr = '0, wr_addr = '0;
  logic [DW-1:0] rd_a_data, rd_b_data;
  logic          wr_en = 1'b0, st_we = 1'b0, exc_en = 1'b0, ret_en = 1'b0;
  logic [DW-1:0] wr_data = '0, st_wdata = '0, exc_ret_addr = '0;
  logic [4:0]    exc_mode = '0;
  logic [DW-1:0] status_o, saved_status_o;
  logic          mode_err, narrow_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  bankreg_file #(.DATA_W(DW)) i_bankreg_file (
    .clk(clk), .rst(rst),
    .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
    .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .st_we(st_we), .st_wdata(st_wdata),
    .exc_en(exc_en), .exc_mode(exc_mode), .exc_ret_addr(exc_ret_addr),
    .ret_en(ret_en),
    .status_o(status_o), .saved_status_o(saved_status_o),
    .mode_err(mode_err), .narrow_err(narrow_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic set_status(input logic [DW-1:0] v);
    st_we = 1'b1; st_wdata = v; tick(); st_we = 1'b0;
  endtask

  task automatic wreg(input logic [3:0] a, input logic [DW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d; tick(); wr_en = 1'b0;
  endtask

  task automatic rchk(input string tag, input logic [3:0] a, input logic [DW-1:0] exp);
    rd_a_addr = a; rd_b_addr = 4'd0; #1;
    check(tag, rd_a_data, exp);
  endtask

  task automatic t_reset();
    check("R1 status", status_o, 32'h0000_0013);
    check("R1 saved", saved_status_o, '0);
    check("R1 mode_err", {31'b0, mode_err}, '0);
    rchk("R1 r0", 4'd0, '0);
    rchk("R1 r13 sup", 4'd13, '0);
    rchk("R5 pc after reset", 4'd15, 32'h8);
  endtask

  task automatic t_user_fill();
    set_status(32'h10);
    for (int i = 0; i < 15; i++) wreg(4'(i), 32'h1000_0000 + i);
    for (int i = 0; i < 15; i++) rchk("R2 user readback", 4'(i), 32'h1000_0000 + i);
    check("R10 user saved zero", saved_status_o, '0);
  endtask

  task automatic t_fast_bank();
    set_status(32'h11);
    rchk("R2 r7 shared in fast", 4'd7, 32'h1000_0007);
    rchk("R3 fresh r8", 4'd8, '0);
    wreg(4'd8, 32'hAAAA_0008);
    wreg(4'd14, 32'hAAAA_000E);
    set_status(32'h10);
    rchk("R3 user r8 kept", 4'd8, 32'h1000_0008);
    rchk("R3 user r14 kept", 4'd14, 32'h1000_000E);
    set_status(32'h11);
    rchk("R3 fast r8 kept", 4'd8, 32'hAAAA_0008);
  endtask

  task automatic t_priv_bank();
    set_status(32'h13);
    rchk("R4 sup r13 private", 4'd13, '0);
    rchk("R4 sup r12 shared", 4'd12, 32'h1000_000C);
    wreg(4'd13, 32'h5555_000D);
    set_status(32'h17);
    rchk("R4 abt r13 private", 4'd13, '0);
    set_status(32'h13);
    rchk("R4 sup r13 kept", 4'd13, 32'h5555_000D);
    set_status(32'h10);
    rchk("R4 user r13 kept", 4'd13, 32'h1000_000D);
    set_status(32'h1F);
    rchk("R2 system r13 shared", 4'd13, 32'h1000_000D);
    set_status(32'h10);
  endtask

  task automatic t_pc();
    wreg(4'd15, 32'h100);
    rd_a_addr = 4'd15; rd_b_addr = 4'd15; #1;
    check("R5 pc port a", rd_a_data, 32'h108);
    check("R5 pc port b", rd_b_data, 32'h108);
    rchk("R5 r14 untouched by pc write", 4'd14, 32'h1000_000E);
  endtask

  task automatic t_exception();
    set_status(32'hF000_0010);
    exc_en = 1'b1; exc_mode = 5'b10010; exc_ret_addr = 32'h200;
    wr_en = 1'b1; wr_addr = 4'd3; wr_data = 32'hDEAD;
    st_we = 1'b1; st_wdata = 32'h13;
    tick();
    exc_en = 1'b0; wr_en = 1'b0; st_we = 1'b0;
    check("R6 status after entry", status_o, 32'hF000_0012);
    check("R6 saved status", saved_status_o, 32'hF000_0010);
    rchk("R6 link loaded", 4'd14, 32'h200);
    rchk("R7 general write dropped", 4'd3, 32'h1000_0003);
    ret_en = 1'b1; tick(); ret_en = 1'b0;
    check("R9 restore", status_o, 32'hF000_0010);
    rchk("R4 user r14 after return", 4'd14, 32'h1000_000E);
    ret_en = 1'b1; tick(); ret_en = 1'b0;
    check("R9 ignored in user", status_o, 32'hF000_0010);
    check("R10 user saved zero", saved_status_o, '0);
  endtask

  task automatic t_exc_narrow_clear();
    set_status(32'h30);
    exc_en = 1'b1; exc_mode = 5'b10001; exc_ret_addr = 32'h300;
    tick(); exc_en = 1'b0;
    check("R6 narrow bit cleared", status_o, 32'h11);
    check("R6 saved narrow status", saved_status_o, 32'h30);
    rchk("R6 fast link loaded", 4'd14, 32'h300);
    rchk("R3 fast r8 intact", 4'd8, 32'hAAAA_0008);
    set_status(32'h10);
  endtask

  task automatic t_bad_exc();
    exc_en = 1'b1; exc_mode = 5'b10000; exc_ret_addr = 32'h400;
    tick();
    check("R8 user target ignored", status_o, 32'h10);
    exc_mode = 5'b10101; tick();
    exc_mode = 5'b11111; tick(); exc_en = 1'b0;
    check("R8 bad target ignored", status_o, 32'h10);
    rchk("R8 r14 unchanged", 4'd14, 32'h1000_000E);
  endtask

  task automatic t_narrow();
    set_status(32'h30);
    rd_b_addr = 4'd0; rd_a_addr = 4'd7; #1;
    check("R11 r7 allowed", {31'b0, narrow_err}, '0);
    rd_a_addr = 4'd8; #1;
    check("R11 r8 flagged", {31'b0, narrow_err}, 32'd1);
    rd_a_addr = 4'd12; #1;
    check("R11 r12 flagged", {31'b0, narrow_err}, 32'd1);
    rd_a_addr = 4'd13; rd_b_addr = 4'd15; #1;
    check("R11 sp/pc allowed", {31'b0, narrow_err}, '0);
    rd_b_addr = 4'd10; #1;
    check("R11 port b flagged", {31'b0, narrow_err}, 32'd1);
    rd_b_addr = 4'd0; wr_addr = 4'd9; #1;
    check("R11 write addr without enable", {31'b0, narrow_err}, '0);
    wr_en = 1'b1; #1;
    check("R11 write addr flagged", {31'b0, narrow_err}, 32'd1);
    wr_en = 1'b0; wr_addr = 4'd0;
    set_status(32'h10);
    rd_a_addr = 4'd9; #1;
    check("R11 wide state no flag", {31'b0, narrow_err}, '0);
  endtask

  task automatic t_bad_mode();
    set_status(32'h15);
    check("R12 mode_err", {31'b0, mode_err}, 32'd1);
    check("R10 bad mode saved zero", saved_status_o, '0);
    rchk("R12 user r13 used", 4'd13, 32'h1000_000D);
    rchk("R12 user r8 used", 4'd8, 32'h1000_0008);
    ret_en = 1'b1; tick(); ret_en = 1'b0;
    check("R9 ignored in bad mode", status_o, 32'h15);
    set_status(32'h10);
    check("R12 mode_err clears", {31'b0, mode_err}, '0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst = 1'b0;
    t_reset();
    t_user_fill();
    t_fast_bank();
    t_priv_bank();
    t_pc();
    t_exception();
    t_exc_narrow_clear();
    t_bad_exc();
    t_narrow();
    t_bad_mode();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule